// File: doc/BRIEF.md
# NAND Flash Power-Up Reset and Identification Sequencer

This block brings an 8-bit NAND flash device out of power-up on its raw pin interface. The interface is chip enable, command and address latch enables, write and read strobes, the data bus and the ready/busy line. It runs two phases in a fixed order. In the first phase it writes the reset command, waits the write-to-busy time and then waits for the device to report ready. It then releases chip enable for a short gap. In the second phase it writes the identification command and one zero address byte, waits the write-to-busy time and reads two bytes. The first of these bytes is the manufacturer code and the second is the device code.

The block starts by itself when reset is released, and again on each `start` pulse received while it is idle. When a sequence ends it pulses `init_done`. At that point it presents the 16-bit identifier and a flag that shows whether the identifier equals a parameterised expected value. If the ready/busy line stays low for too long, the sequence ends with an error flag instead of hanging.

All pin timings are parameters counted in clock cycles. The ready/busy input passes through a synchronizer before the sequencer uses it.

Top module: `nand_init_seq`

## Requirements
- R1: While `rst_n` is low, the block drives `nand_ce_n`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_dq_oe`=0 and `init_done`=0.
- R2: After reset is released, the block starts without any `start` pulse. Its first bus write is command byte FFh, latched on the rising edge of `nand_we_n` with `nand_cle`=1, `nand_ale`=0 and `nand_ce_n`=0.
- R3: After the reset command, the block waits `T_WB` cycles. It then waits until the synchronized ready/busy input is high (1 = ready). It then holds `nand_ce_n` high for `T_CEH` cycles before the identification phase begins.
- R4: The identification phase writes command byte 90h with `nand_cle`=1. This is followed by exactly one address write of 00h with `nand_ale`=1 and `nand_cle`=0. Every strobe happens with `nand_ce_n`=0.
- R5: After the address write and a wait of `T_WB` cycles, the block performs exactly two read strobes. The byte read in the first becomes `flash_id[15:8]` and the byte read in the second becomes `flash_id[7:0]`.
- R6: `init_done` is high for exactly one cycle per sequence. From that cycle on, `flash_id`, `id_match` and `init_err` are valid and hold until the next sequence starts.
- R7: `id_match` is 1 exactly when the sequence ended without error and `flash_id` equals `EXPECT_ID` (default 16'hEC76).
- R8: If ready/busy stays low for `T_BUSY_MAX` cycles, the sequence ends with `init_err`=1, `flash_id`=0 and `id_match`=0. No identification command is issued and chip enable is released.
- R9: A `start` pulse during a running sequence is ignored. A `start` pulse while idle runs the whole sequence again and clears a previous `init_err`.
- R10: `nand_we_n` and `nand_re_n` are never low together, and `nand_dq_oe` is never high while `nand_re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new sequence while idle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Command/address byte to the device |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Ready/busy from the device, 1 = ready |
| init_done | output | 1 | One-cycle end-of-sequence pulse |
| init_err | output | 1 | Ready/busy timeout occurred |
| flash_id | output | 16 | Manufacturer code (upper byte) and device code (lower byte) |
| id_match | output | 1 | Identifier equals `EXPECT_ID` and no error |

## Verification
A sequencer that leaves its phase early shows up at the pins within one bus cycle. The symptom is an identification command while ready/busy is still low, or a strobe while chip enable is high. A bench-side device model catches either one on the strobe edge where it occurs. A wrong byte-capture order or a wrong timeout path does not appear until `init_done`, where `flash_id`, `id_match` and `init_err` disagree with the values computed from the bytes the model returned. A stuck state appears as a missing `init_done` within the bounded wait of each run.

// File: rtl/nis_pkg.sv
package nis_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_CMD,
    S_RST_TWB,
    S_RST_BSY,
    S_CE_GAP,
    S_ID_CMD,
    S_ID_ADR,
    S_ID_TWB,
    S_ID_RD0,
    S_ID_RD1,
    S_DONE
  } nis_state_e;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_READ_ID = 8'h90;
  localparam logic [7:0] ID_ADDR    = 8'h00;
endpackage

// File: rtl/nis_sync.sv
module nis_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nis_counter.sv
module nis_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: phase limits all sit below the counter's top value
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> (cnt_q != {W{1'b1}}));
endmodule

// File: rtl/nis_id_capture.sv
module nis_id_capture #(
  parameter logic [15:0] EXPECT_ID = 16'hEC76
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap_hi,
  input  logic        cap_lo,
  input  logic        judge,
  input  logic [7:0]  byte_in,
  output logic [15:0] id,
  output logic        match
);
  logic [15:0] id_q, id_d;
  logic        match_q, match_d;

  always_comb begin
    id_d    = id_q;
    match_d = match_q;
    if (clr) begin
      id_d    = '0;
      match_d = 1'b0;
    end else begin
      if (cap_hi) id_d[15:8] = byte_in;
      if (cap_lo) id_d[7:0]  = byte_in;
      if (judge)  match_d    = (id_q == EXPECT_ID);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      match_q <= 1'b0;
    end else begin
      id_q    <= id_d;
      match_q <= match_d;
    end
  end

  assign id    = id_q;
  assign match = match_q;

  // R5: the two bytes are taken at different moments
  assert_one_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_hi && cap_lo));
endmodule

// File: rtl/nand_init_seq.sv
module nand_init_seq
  import nis_pkg::*;
#(
  parameter int          T_WP        = 2,
  parameter int          T_WH        = 2,
  parameter int          T_RP        = 2,
  parameter int          T_RH        = 2,
  parameter int          T_WB        = 13,
  parameter int          T_CEH       = 4,
  parameter int          T_BUSY_MAX  = 62500,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] EXPECT_ID   = 16'hEC76
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb,
  output logic        init_done,
  output logic        init_err,
  output logic [15:0] flash_id,
  output logic        id_match
);
  localparam int WR_LEN  = T_WP + T_WH;
  localparam int RD_LEN  = T_RP + T_RH;
  localparam int M1      = (WR_LEN > RD_LEN) ? WR_LEN : RD_LEN;
  localparam int M2      = (M1 > T_WB) ? M1 : T_WB;
  localparam int M3      = (M2 > T_CEH) ? M2 : T_CEH;
  localparam int LIM_MAX = (M3 > T_BUSY_MAX) ? M3 : T_BUSY_MAX;
  localparam int CW      = $clog2(LIM_MAX + 1);

  localparam logic [CW-1:0] WR_LAST  = CW'(WR_LEN - 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_LEN - 1);
  localparam logic [CW-1:0] WP_END   = CW'(T_WP);
  localparam logic [CW-1:0] RP_END   = CW'(T_RP);
  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);
  localparam logic [CW-1:0] WB_LAST  = CW'(T_WB - 1);
  localparam logic [CW-1:0] CEH_LAST = CW'(T_CEH - 1);
  localparam logic [CW-1:0] BSY_LAST = CW'(T_BUSY_MAX - 1);

  nis_state_e    state_q, state_d;
  logic          auto_q, auto_d;
  logic          err_q, err_d;
  logic [CW-1:0] cnt;
  logic          cnt_clr;
  logic          rb_s;
  logic          launch;
  logic          cap_hi, cap_lo, judge;
  logic          wr_phase, rd_phase;

  nis_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (nand_rb),
    .q    (rb_s)
  );

  nis_counter #(.W(CW)) u_phase_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .en   (1'b1),
    .cnt  (cnt)
  );

  nis_id_capture #(.EXPECT_ID(EXPECT_ID)) u_id (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (launch),
    .cap_hi (cap_hi),
    .cap_lo (cap_lo),
    .judge  (judge),
    .byte_in(nand_dq_in),
    .id     (flash_id),
    .match  (id_match)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    cap_hi  = 1'b0;
    cap_lo  = 1'b0;
    judge   = 1'b0;
    unique case (state_q)
      S_IDLE: if (auto_q || start) begin
        state_d = S_RST_CMD;
        launch  = 1'b1;
      end
      S_RST_CMD: if (cnt == WR_LAST)  state_d = S_RST_TWB;
      S_RST_TWB: if (cnt == WB_LAST)  state_d = S_RST_BSY;
      S_RST_BSY: begin
        if (rb_s)                  state_d = S_CE_GAP;
        else if (cnt == BSY_LAST)  state_d = S_DONE;
      end
      S_CE_GAP:  if (cnt == CEH_LAST) state_d = S_ID_CMD;
      S_ID_CMD:  if (cnt == WR_LAST)  state_d = S_ID_ADR;
      S_ID_ADR:  if (cnt == WR_LAST)  state_d = S_ID_TWB;
      S_ID_TWB:  if (cnt == WB_LAST)  state_d = S_ID_RD0;
      S_ID_RD0: begin
        cap_hi = (cnt == RP_LAST);
        if (cnt == RD_LAST) state_d = S_ID_RD1;
      end
      S_ID_RD1: begin
        cap_lo = (cnt == RP_LAST);
        if (cnt == RD_LAST) begin
          state_d = S_DONE;
          judge   = 1'b1;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    auto_d = auto_q;
    err_d  = err_q;
    if (launch) begin
      auto_d = 1'b0;
      err_d  = 1'b0;
    end else if (state_q == S_RST_BSY && !rb_s && cnt == BSY_LAST) begin
      err_d = 1'b1;
    end
  end

  assign cnt_clr = (state_q != state_d) || (state_q == S_IDLE);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      auto_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_d;
      err_q   <= err_d;
    end
  end

  // pin decode
  assign wr_phase = (state_q == S_RST_CMD) || (state_q == S_ID_CMD) ||
                    (state_q == S_ID_ADR);
  assign rd_phase = (state_q == S_ID_RD0) || (state_q == S_ID_RD1);

  always_comb begin
    unique case (state_q)
      S_RST_CMD: nand_dq_out = OP_RESET;
      S_ID_CMD:  nand_dq_out = OP_READ_ID;
      default:   nand_dq_out = ID_ADDR;
    endcase
  end

  assign nand_ce_n  = (state_q == S_IDLE) || (state_q == S_CE_GAP) ||
                      (state_q == S_DONE);
  assign nand_cle   = (state_q == S_RST_CMD) || (state_q == S_ID_CMD);
  assign nand_ale   = (state_q == S_ID_ADR);
  assign nand_we_n  = !(wr_phase && (cnt < WP_END));
  assign nand_re_n  = !(rd_phase && (cnt < RP_END));
  assign nand_dq_oe = wr_phase;
  assign init_done  = (state_q == S_DONE);
  assign init_err   = err_q;

  // R10: strobes are mutually exclusive
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R10: no bus contention while the device drives data
  assert_no_drive_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);
  // R4: strobes only with chip selected
  assert_strobe_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  // R6: end-of-sequence pulse lasts one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done);
  // R7: an errored sequence never reports a match
  assert_err_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |-> !id_match);
  // R3: chip enable held low throughout the ready wait
  assert_ce_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RST_BSY && !rb_s && cnt != BSY_LAST) |=> !nand_ce_n);
endmodule

// File: tb/nand_init_seq_test.sv
`timescale 1ns/1ps
module nand_init_seq_test;
  localparam int T_BUSY_MAX = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_rb;
  logic        init_done, init_err, id_match;
  logic [15:0] flash_id;

  always #4 clk = ~clk;

  nand_init_seq #(
    .T_WP(2), .T_WH(2), .T_RP(2), .T_RH(2), .T_WB(5), .T_CEH(3),
    .T_BUSY_MAX(T_BUSY_MAX), .SYNC_STAGES(2), .EXPECT_ID(16'hEC76)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
    .init_done(init_done), .init_err(init_err), .flash_id(flash_id),
    .id_match(id_match)
  );

  // device model state
  logic [7:0] mfr_code = 8'hEC;
  logic [7:0] dev_code = 8'h76;
  int busy_len = 10;
  int n_ff = 0, n_90 = 0, n_adr = 0, n_other = 0, order_bad = 0, ce_bad_w = 0;
  int gap_at_ff = 0;
  logic [7:0] last_cmd = 8'h00;
  int n_gap = 0;
  int n_rd = 0, ce_bad_r = 0, rd_ptr = 0, rd_seen90 = 0, rd_order_bad = 0;
  int n_done = 0;
  int n_chk = 0, n_fail = 0;

  always @(posedge nand_we_n) begin
    if (nand_ce_n) ce_bad_w++;
    if (nand_cle && !nand_ale) begin
      last_cmd = nand_dq_out;
      if (nand_dq_out == 8'hFF) begin
        n_ff++;
        gap_at_ff = n_gap;
      end else if (nand_dq_out == 8'h90) begin
        n_90++;
        if (!nand_rb || n_gap == gap_at_ff) order_bad++;
      end else n_other++;
    end else if (nand_ale && !nand_cle) begin
      if (nand_dq_out == 8'h00 && last_cmd == 8'h90) n_adr++;
      else n_other++;
    end else n_other++;
  end

  always @(posedge nand_ce_n) if (nand_rb && n_ff > 0) n_gap++;

  initial begin
    nand_rb = 1'b1;
    forever begin
      @(n_ff);
      @(posedge clk); #1 nand_rb = 1'b0;
      repeat (busy_len) @(posedge clk);
      #1 nand_rb = 1'b1;
    end
  end

  always @(negedge nand_re_n) begin
    n_rd++;
    if (nand_ce_n) ce_bad_r++;
    if (rd_seen90 != n_90) begin
      rd_seen90 = n_90;
      rd_ptr = 0;
    end
    if (n_adr == 0) rd_order_bad++;
    nand_dq_in = (rd_ptr == 0) ? mfr_code : ((rd_ptr == 1) ? dev_code : 8'h5A);
    rd_ptr++;
  end

  always @(posedge clk) if (init_done) n_done++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle_pins(input string tag);
    chk(nand_ce_n === 1'b1, {tag, " ce_n"}, 32'(nand_ce_n), 1);
    chk(nand_we_n === 1'b1 && nand_re_n === 1'b1, {tag, " strobes"},
        {nand_we_n, nand_re_n}, 2'b11);
    chk(nand_cle === 1'b0 && nand_ale === 1'b0 && nand_dq_oe === 1'b0,
        {tag, " latches/oe"}, {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(init_done === 1'b0, {tag, " done"}, 32'(init_done), 0);
  endtask

  // mode 0: start pulse, mode 1: release reset
  task automatic run_seq(input logic [7:0] m, input logic [7:0] d, input int bl,
                         input bit exp_err, input bit mode);
    int b_ff, b_90, b_adr, b_oth, b_ord, b_cew, b_rd, b_cer, b_rord, b_done;
    int waited;
    logic [15:0] exp_id;
    mfr_code = m; dev_code = d; busy_len = bl;
    b_ff = n_ff; b_90 = n_90; b_adr = n_adr; b_oth = n_other; b_ord = order_bad;
    b_cew = ce_bad_w; b_rd = n_rd; b_cer = ce_bad_r; b_rord = rd_order_bad;
    b_done = n_done;
    @(negedge clk);
    if (mode) rst_n = 1'b1;
    else begin
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (init_done !== 1'b1 && waited < 2000) begin
      @(negedge clk); waited++;
    end
    chk(init_done === 1'b1, "R6 done seen (watchdog)", 32'(waited), 0);
    exp_id = exp_err ? 16'h0000 : {m, d};
    chk(init_err === exp_err, "R8 error flag", 32'(init_err), 32'(exp_err));
    chk(flash_id === exp_id, "R5 id byte order", flash_id, exp_id);
    chk(id_match === (!exp_err && exp_id == 16'hEC76), "R7 match flag",
        32'(id_match), 32'(!exp_err && exp_id == 16'hEC76));
    chk(n_ff - b_ff == 1, "R2 one reset command", n_ff - b_ff, 1);
    chk(n_other == b_oth, "R4 no stray writes", n_other - b_oth, 0);
    chk(ce_bad_w == b_cew && ce_bad_r == b_cer, "R4 strobes selected",
        (ce_bad_w - b_cew) + (ce_bad_r - b_cer), 0);
    if (!exp_err) begin
      chk(n_90 - b_90 == 1 && n_adr - b_adr == 1, "R4 id cmd and one addr",
          {16'(n_90 - b_90), 16'(n_adr - b_adr)}, 32'h0001_0001);
      chk(order_bad == b_ord, "R3 id cmd after ready and ce gap",
          order_bad - b_ord, 0);
      chk(n_rd - b_rd == 2 && rd_order_bad == b_rord, "R5 two reads after addr",
          n_rd - b_rd, 2);
    end else begin
      chk(n_90 == b_90, "R8 no id cmd on timeout", n_90 - b_90, 0);
    end
    @(negedge clk);
    chk(init_done === 1'b0 && n_done - b_done == 1, "R6 single pulse",
        n_done - b_done, 1);
    chk(flash_id === exp_id && init_err === exp_err, "R6 results held",
        flash_id, exp_id);
    chk(nand_ce_n === 1'b1, "R8 ce released at end", 32'(nand_ce_n), 1);
    while (nand_rb !== 1'b1) @(negedge clk);
  endtask

  // mfr[39:32] dev[31:24] busy[23:8] err[0]
  localparam logic [39:0] VEC [6] = '{
    {8'hEC, 8'h76, 16'd20,   8'd0},
    {8'hEC, 8'h75, 16'd10,   8'd0},
    {8'h2C, 8'h76, 16'd0,    8'd0},
    {8'h00, 8'h00, 16'd50,   8'd0},
    {8'hEC, 8'h76, 16'd1000, 8'd1},
    {8'hFF, 8'hFF, 16'd100,  8'd0}
  };

  initial begin
    #1;
    check_idle_pins("R1 reset state");
    repeat (3) @(negedge clk);
    check_idle_pins("R1 held in reset");
    // R2: automatic first run on reset release
    run_seq(8'hEC, 8'h76, 15, 1'b0, 1'b1);
    foreach (VEC[i]) begin
      run_seq(VEC[i][39:32], VEC[i][31:24], int'(VEC[i][23:8]), VEC[i][0], 1'b0);
    end
    // R9: start during a run is ignored
    begin
      int b_ff, b_done;
      b_ff = n_ff; b_done = n_done;
      mfr_code = 8'h98; dev_code = 8'h12; busy_len = 40;
      @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (200) @(negedge clk);
      chk(n_ff - b_ff == 1 && n_done - b_done == 1, "R9 start ignored while running",
          {16'(n_ff - b_ff), 16'(n_done - b_done)}, 32'h0001_0001);
      chk(flash_id === 16'h9812, "R9 run result intact", flash_id, 16'h9812);
      chk(init_done === 1'b0 && nand_ce_n === 1'b1, "R9 back to idle",
          {init_done, nand_ce_n}, 2'b01);
    end
    // R1: reset in the middle of a run
    busy_len = 100;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1 check_idle_pins("R1 mid-run reset");
    chk(flash_id === 16'h0000 && id_match === 1'b0 && init_err === 1'b0,
        "R1 results cleared", flash_id, 0);
    while (nand_rb !== 1'b1) @(negedge clk);
    run_seq(8'hEC, 8'h76, 25, 1'b0, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule